// File: doc/BRIEF.md
# BCD Decimal Adjust Unit

This block repairs an 8-bit accumulator that holds the binary sum of two packed-BCD operands, so that it again reads as two decimal digits. It takes the accumulator and the current flag byte, decides whether each digit needs a correction of six, and returns the corrected accumulator together with a fresh flag byte.

The correction runs in two stages. The low digit is fixed first. The high digit is then examined on the value that the first stage produced, not on the original input. A high digit of 9 that picks up a carry from the low-digit fix therefore also receives the high correction. A parameter picks between a purely combinational output and a registered output with a valid strobe; the registered form is the default. A second parameter, off by default, is reserved for negative corrections after a subtraction.

Top module: `bcd_adjust_unit`

## Requirements
- R1: When the low four bits of the input accumulator exceed 9, or the incoming half-carry flag (bit 4 of the flag byte) is 1, 0x06 is added to the accumulator.
- R2: When the high nibble of the value after the R1 stage exceeds 9, or the incoming carry flag (bit 0) is 1, 0x60 is added and the outgoing carry (bit 0) is 1. Example: input 0x9A with both flags clear gives 0x00 with carry set, a total correction of 0x66.
- R3: When the R2 correction is not applied, the outgoing carry (bit 0) is 0.
- R4: The outgoing half-carry (bit 4) is 1 exactly when one of the correction additions carries out of bit 3.
- R5: The outgoing sign flag (bit 7) equals bit 7 of the result, and the zero flag (bit 6) is 1 exactly when the result is 0x00.
- R6: The parity flag (bit 2) is 1 when the result holds an even number of 1 bits.
- R7: The subtract flag (bit 1) is copied from input to output unchanged, and output flag bits 5 and 3 are always 0.
- R8: With the registered output, results and outValid appear on the first rising edge after the edge that sampled inValid high. While inValid is low, outValid is 0 and the result and flags hold their values.
- R9: While rstN is low, accOut, flagsOut and outValid are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input operands are valid this cycle |
| accIn | input | 8 | Accumulator after a binary BCD addition |
| flagsIn | input | 8 | Incoming flags: bit 0 carry, bit 1 subtract, bit 4 half-carry |
| accOut | output | 8 | Decimal-adjusted accumulator |
| flagsOut | output | 8 | Outgoing flags: 7 sign, 6 zero, 4 half-carry, 2 parity, 1 subtract, 0 carry |
| outValid | output | 1 | Result registers were loaded on the last edge |

## Verification
In the default registered form, every output (accumulator, each flag and the strobe) is due exactly one rising edge after the edge that samples the input. The bench drives each input on a falling edge and reads the outputs at the next falling edge, which is half a period after the loading edge. It sweeps all 256 accumulator values under all four half-carry and carry combinations. After each sweep step it drops inValid and presents different data for one cycle, then confirms that the outputs held and that the strobe fell.

// File: rtl/bcdadj_pkg.sv
package bcdadj_pkg;
  // flag byte bit positions
  localparam int FlagC = 0;
  localparam int FlagN = 1;
  localparam int FlagP = 2;
  localparam int FlagH = 4;
  localparam int FlagZ = 6;
  localparam int FlagS = 7;

  // strobes from control to datapath
  typedef struct packed {
    logic lowFix;
    logic highFix;
    logic negate;
    logic load;
  } adj_ctrl_t;
endpackage

// File: rtl/bcdadj_ctrl.sv
module bcdadj_ctrl
  import bcdadj_pkg::*;
#(
  parameter int NIB_W  = 4,
  parameter int SUB_EN = 0
) (
  input  logic             inValid,
  input  logic [NIB_W-1:0] lowDigit,
  input  logic [NIB_W-1:0] midHighDigit,
  input  logic             halfIn,
  input  logic             carryIn,
  input  logic             subIn,
  output adj_ctrl_t        ctrl
);
  localparam logic [NIB_W-1:0] DigitMax = NIB_W'(9);

  always_comb begin
    ctrl.lowFix  = (lowDigit > DigitMax) || halfIn;
    // high check is made on the value after the low-digit stage
    ctrl.highFix = (midHighDigit > DigitMax) || carryIn;
    ctrl.negate  = (SUB_EN != 0) && subIn;
    ctrl.load    = inValid;
  end
endmodule

// File: rtl/bcdadj_datapath.sv
module bcdadj_datapath
  import bcdadj_pkg::*;
#(
  parameter int ACC_W   = 8,
  parameter int REG_OUT = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  adj_ctrl_t        ctrl,
  input  logic [ACC_W-1:0] accIn,
  input  logic             subIn,
  output logic [ACC_W-1:0] midVal,
  output logic [ACC_W-1:0] accOut,
  output logic [7:0]       flagsOut,
  output logic             outValid
);
  localparam int NIB_W = ACC_W / 2;
  localparam logic [ACC_W-1:0] LowStep  = ACC_W'(6);
  localparam logic [ACC_W-1:0] HighStep = ACC_W'(6) << NIB_W;

  logic [ACC_W-1:0] lowAddend, highAddend, finVal;
  logic             lowHc, highHc;
  logic [ACC_W-1:0] accNext;
  logic [7:0]       flagsNext;

  // carry (or borrow) out of the low nibble for one correction step
  function automatic logic nibCarry(input logic [ACC_W-1:0] a,
                                    input logic [ACC_W-1:0] b,
                                    input logic neg);
    logic [NIB_W:0] s;
    if (neg) begin
      s = {1'b0, a[NIB_W-1:0]} - {1'b0, b[NIB_W-1:0]};
    end else begin
      s = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]};
    end
    return s[NIB_W];
  endfunction

  always_comb begin
    lowAddend  = ctrl.lowFix  ? LowStep  : '0;
    highAddend = ctrl.highFix ? HighStep : '0;
    midVal = ctrl.negate ? (accIn - lowAddend) : (accIn + lowAddend);
    lowHc  = nibCarry(accIn, lowAddend, ctrl.negate);
    finVal = ctrl.negate ? (midVal - highAddend) : (midVal + highAddend);
    highHc = nibCarry(midVal, highAddend, ctrl.negate);
    accNext = finVal;
    flagsNext = '0;
    flagsNext[FlagS] = finVal[ACC_W-1];
    flagsNext[FlagZ] = (finVal == '0);
    flagsNext[FlagH] = lowHc | highHc;
    flagsNext[FlagP] = ~^finVal;
    flagsNext[FlagN] = subIn;
    flagsNext[FlagC] = ctrl.highFix;
  end

  generate
    if (REG_OUT != 0) begin : g_reg
      logic [ACC_W-1:0] accQ;
      logic [7:0]       flagsQ;
      logic             validQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          accQ   <= '0;
          flagsQ <= '0;
          validQ <= 1'b0;
        end else begin
          validQ <= ctrl.load;
          if (ctrl.load) begin
            accQ   <= accNext;
            flagsQ <= flagsNext;
          end
        end
      end
      assign accOut   = accQ;
      assign flagsOut = flagsQ;
      assign outValid = validQ;
    end else begin : g_comb
      logic unusedClk;
      assign unusedClk = clk ^ rstN;
      assign accOut   = rstN ? accNext : '0;
      assign flagsOut = rstN ? flagsNext : '0;
      assign outValid = rstN & ctrl.load;
    end
  endgenerate
endmodule

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit
  import bcdadj_pkg::*;
#(
  parameter int REG_OUT = 1,
  parameter int SUB_EN  = 0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [7:0] accIn,
  input  logic [7:0] flagsIn,
  output logic [7:0] accOut,
  output logic [7:0] flagsOut,
  output logic       outValid
);
  localparam int AccW = 8;
  localparam int NibW = AccW / 2;

  adj_ctrl_t        ctrl;
  logic [AccW-1:0]  midVal;

  bcdadj_ctrl #(.NIB_W(NibW), .SUB_EN(SUB_EN)) u_ctrl (
    .inValid      (inValid),
    .lowDigit     (accIn[NibW-1:0]),
    .midHighDigit (midVal[AccW-1:NibW]),
    .halfIn       (flagsIn[FlagH]),
    .carryIn      (flagsIn[FlagC]),
    .subIn        (flagsIn[FlagN]),
    .ctrl         (ctrl)
  );

  bcdadj_datapath #(.ACC_W(AccW), .REG_OUT(REG_OUT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .accIn    (accIn),
    .subIn    (flagsIn[FlagN]),
    .midVal   (midVal),
    .accOut   (accOut),
    .flagsOut (flagsOut),
    .outValid (outValid)
  );
endmodule

// File: rtl/bcdadj_checker.sv
module bcdadj_checker
  import bcdadj_pkg::*;
#(
  parameter int REG_OUT = 1
) (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic [7:0] accIn,
  input logic [7:0] flagsIn,
  input logic [7:0] accOut,
  input logic [7:0] flagsOut,
  input logic       outValid
);
  // R6
  parity_even_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (flagsOut[FlagP] == ~^accOut));
  // R5
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (flagsOut[FlagZ] == (accOut == 8'h00)));
  // R7
  spare_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (flagsOut[5] == 1'b0 && flagsOut[3] == 1'b0));

  generate
    if (REG_OUT != 0) begin : g_seq
      // R8
      valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> outValid);
      // R8
      idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> (!outValid && $stable(accOut) && $stable(flagsOut)));
      // R7
      sub_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> (flagsOut[FlagN] == $past(flagsIn[FlagN])));
      // R2
      carry_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && flagsIn[FlagC]) |=> flagsOut[FlagC]);
    end
  endgenerate
endmodule

bind bcd_adjust_unit bcdadj_checker #(.REG_OUT(REG_OUT)) u_bcdadj_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .accIn    (accIn),
  .flagsIn  (flagsIn),
  .accOut   (accOut),
  .flagsOut (flagsOut),
  .outValid (outValid)
);

// File: tb/tb_bcd_adjust_unit.sv
module tb_bcd_adjust_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] accIn = '0;
  logic [7:0] flagsIn = '0;
  logic [7:0] accOut, flagsOut;
  logic       outValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  bcd_adjust_unit dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .accIn(accIn),
    .flagsIn(flagsIn), .accOut(accOut), .flagsOut(flagsOut), .outValid(outValid)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model computed from the requirements
  task automatic refModel(input logic [7:0] a, input logic h, input logic c,
                          output logic [7:0] r, output logic hOut, output logic cOut);
    int v;
    v = a; hOut = 1'b0; cOut = 1'b0;
    if ((v % 16) > 9 || h) begin
      if ((v % 16) + 6 > 15) hOut = 1'b1;
      v = (v + 6) % 256;
    end
    if ((v / 16) > 9 || c) begin
      v = (v + 'h60) % 256;
      cOut = 1'b1;
    end
    r = v[7:0];
  endtask

  initial begin
    logic [7:0] er, holdAcc, holdFlags;
    logic eh, ec;
    int ones;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 accOut", accOut, 0);
    chk("R9 flagsOut", flagsOut, 0);
    chk("R9 outValid", outValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    for (int hc = 0; hc < 4; hc++) begin
      for (int a = 0; a < 256; a++) begin
        accIn = a[7:0];
        flagsIn = 8'h28;            // bits 5 and 3 set; must not pass
        flagsIn[4] = hc[1];
        flagsIn[0] = hc[0];
        flagsIn[1] = a[0] ^ hc[1];
        flagsIn[7] = a[1];
        flagsIn[6] = a[2];
        flagsIn[2] = a[3];
        inValid = 1'b1;
        @(negedge clk);
        refModel(a[7:0], hc[1], hc[0], er, eh, ec);
        ones = $countones(er);
        chk("R8 outValid", outValid, 1);
        chk("R1/R2 accOut", accOut, er);
        if (ec) chk("R2 carry", flagsOut[0], 1);
        else    chk("R3 carry", flagsOut[0], 0);
        chk("R4 halfcarry", flagsOut[4], eh);
        chk("R5 sign", flagsOut[7], er[7]);
        chk("R5 zero", flagsOut[6], (er == 0));
        chk("R6 parity", flagsOut[2], (ones % 2 == 0));
        chk("R7 subtract", flagsOut[1], a[0] ^ hc[1]);
        chk("R7 spare", {flagsOut[5], flagsOut[3]}, 0);
        // idle cycle with changed data: outputs must hold
        holdAcc = accOut; holdFlags = flagsOut;
        inValid = 1'b0;
        accIn = ~a[7:0];
        flagsIn = ~flagsIn;
        @(negedge clk);
        chk("R8 idle valid", outValid, 0);
        chk("R8 idle hold", {accOut, flagsOut}, {holdAcc, holdFlags});
      end
    end
    // R2 named corner: 0x9A no flags -> 0x00 with carry (total 0x66)
    accIn = 8'h9A; flagsIn = 8'h00; inValid = 1'b1;
    @(negedge clk);
    chk("R2 0x9A corner", {accOut, flagsOut[0]}, {8'h00, 1'b1});
    // R1 corner: 0x3C no flags -> 0x42 (total 0x06)
    accIn = 8'h3C; flagsIn = 8'h00;
    @(negedge clk);
    chk("R1 0x3C corner", accOut, 8'h42);
    inValid = 1'b0;
    // R9 reset again
    rstN = 1'b0;
    @(negedge clk);
    chk("R9 reapplied", {accOut, flagsOut, 7'd0, outValid}, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule